// File: doc/BRIEF.md
# Byte Serial Peripheral Controller with Select-Line Fault Detection

This block moves one byte at a time over a four-wire serial link. It can act as the clock-driving side (master) or the clock-following side (slave). A host talks to it through three byte-wide registers: control, status and data. There is one shift register and one receive buffer. Writing the data register loads the shift register directly. Reading the data register returns the receive buffer. The receive buffer is updated only when a byte finishes.

In master mode the serial clock comes from a divider of the system clock, with the clock idling low and data sampled on the rising edge. In slave mode the incoming select, clock and data lines are synchronised before use. If the select line is at a level that breaks the protocol, the block raises a fault. In master mode the fault clears the enable bit. In slave mode the fault drops the partial byte and waits for select to return low. One interrupt line merges three sources, and each source has its own enable.

The controller runs a five-state machine:
- IDLE: waiting.
- MLOW and MHIGH: the two halves of each master clock period.
- SXFER: slave selected.
- SFAULT: slave waiting out a fault.

The transitions are:
- IDLE→MLOW on a data write while enabled as master.
- MLOW→MHIGH on a divider tick.
- MHIGH→MLOW on a tick before the eighth bit, and MHIGH→IDLE on the tick of the eighth bit.
- IDLE→SXFER when select goes low in slave mode.
- SXFER→IDLE when select rises between bytes.
- SXFER→SFAULT when select rises mid-byte.
- SFAULT→SXFER when select falls again.
- Any master state→IDLE on a master fault or when master mode is turned off.
- Any slave state→IDLE when slave mode is turned off.

Top module: `spi_mf_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x02 (only transmit-empty set), and irq, sck_o and miso_o are 0.
- R2: With control bit 2 clear, a master transfer shifts the data byte out on mosi_o MSB first and receives miso_i MSB first into the receive buffer.
- R3: With control bit 2 set, both directions shift LSB first.
- R4: In master mode sck_o idles low and gives exactly 8 pulses per byte, each high for HALF_DIV system clocks.
- R5: Status bit 1 (transmit-empty) clears on a data write that loads the shift register and sets at byte end. Status bit 0 (done) sets at byte end and clears on a data-register read. When a set and a clear of done fall in the same cycle, the set wins.
- R6: Reading the data register (address 2) during a transfer returns the previous received byte, not the shift register.
- R7: With control bits 0 (enable) and 1 (master) set, a low level on ss_n_i sets the fault flag (status bit 2), clears the enable bit, aborts any transfer and holds sck_o low.
- R8: In slave mode with ss_n_i low, the block receives 8 bits from sck_i/mosi_i into the receive buffer and presents its loaded byte on miso_o in the selected order.
- R9: In slave mode, a rise of ss_n_i mid-byte sets the fault flag and discards the partial byte. The next low level of ss_n_i starts a fresh byte.
- R10: A status-register read (address 1) clears the fault flag. A fault arising in the same cycle as that read leaves the flag set.
- R11: With control bit 3 clear, irq follows the done flag. With it set, irq follows transmit-empty and done has no effect.
- R12: Control bit 4 gates the fault flag onto irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Merged interrupt |
| sck_i | input | 1 | Serial clock in (slave mode) |
| sck_o | output | 1 | Serial clock out (master mode) |
| mosi_i | input | 1 | Serial data in (slave mode) |
| mosi_o | output | 1 | Serial data out (master mode) |
| miso_i | input | 1 | Serial data in (master mode) |
| miso_o | output | 1 | Serial data out (slave mode, 0 when unselected) |
| ss_n_i | input | 1 | Active-low select input |

## Verification
The fault detector and the status-read clear can act on the fault flag in the same clock edge. The bench lowers ss_n_i in master mode and times a status read so that its strobe lands on the exact edge where the synchronised select first sets the flag. That read must still show the flag clear, and the read after it must show the flag set, which proves that setting takes priority. A second pairing, done being set while transmit-empty-driven interrupts are enabled, is judged at the irq pin.

// File: rtl/spi_mf_pkg.sv
`timescale 1ns/1ps
package spi_mf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MLOW,
        ST_MHIGH,
        ST_SXFER,
        ST_SFAULT
    } spi_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    localparam int C_EN     = 0;
    localparam int C_MASTER = 1;
    localparam int C_LSB    = 2;
    localparam int C_TXEIE  = 3;
    localparam int C_MFIE   = 4;

    localparam int S_DONE   = 0;
    localparam int S_TXE    = 1;
    localparam int S_MFAULT = 2;

endpackage

// File: rtl/spi_mf_sync.sv
`timescale 1ns/1ps
module spi_mf_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
            else        chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_mf_tick.sv
`timescale 1ns/1ps
module spi_mf_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (clear || tick)  cnt <= '0;
        else                     cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/spi_mf_ctrl.sv
`timescale 1ns/1ps
module spi_mf_ctrl
    import spi_mf_pkg::*;
#(
    parameter int HALF_DIV    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq,
    input  logic          sck_i,
    output logic          sck_o,
    input  logic          mosi_i,
    output logic          mosi_o,
    input  logic          miso_i,
    output logic          miso_o,
    input  logic          ss_n_i
);
    localparam int BCW = $clog2(DW);

    spi_state_e st, st_nx;

    logic en, master, lsb, txe_ie, mf_ie;
    logic [DW-1:0] shreg, rx_buf, shifted;
    logic samp, phase_hi, done, txe, mfault, sck_d;
    logic [BCW-1:0] bcnt;
    logic ss_s, sck_s, mosi_s, tick, tick_clr;
    logic wr_ctrl, wr_data, rd_stat, rd_data;
    logic m_fault, s_fault, s_mid, last_bit, sck_rise, sck_fall;
    logic m_end, s_end, byte_end, can_load, m_active, bit_out;

    spi_mf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ss_n_i, sck_i, mosi_i}),
        .q({ss_s, sck_s, mosi_s})
    );

    assign m_active = (st == ST_MLOW) || (st == ST_MHIGH);
    assign tick_clr = !m_active;

    spi_mf_tick #(.HALF(HALF_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clear(tick_clr), .tick(tick)
    );

    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign wr_data  = wr_en && (addr == A_DATA);
    assign rd_stat  = rd_en && (addr == A_STAT);
    assign rd_data  = rd_en && (addr == A_DATA);
    assign sck_rise = sck_s && !sck_d;
    assign sck_fall = !sck_s && sck_d;
    assign last_bit = (bcnt == BCW'(DW - 1));
    assign s_mid    = (bcnt != '0) || phase_hi;
    assign m_fault  = en && master && !ss_s;
    assign s_fault  = (st == ST_SXFER) && ss_s && s_mid;
    assign m_end    = (st == ST_MHIGH) && tick && last_bit && !m_fault;
    assign s_end    = (st == ST_SXFER) && !ss_s && sck_fall && last_bit;
    assign byte_end = m_end || s_end;
    assign can_load = !m_active && !((st == ST_SXFER) && s_mid);
    assign shifted  = lsb ? {samp, shreg[DW-1:1]} : {shreg[DW-2:0], samp};
    assign bit_out  = lsb ? shreg[0] : shreg[DW-1];

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (m_fault)                         st_nx = ST_IDLE;
                else if (en && master && wr_data)    st_nx = ST_MLOW;
                else if (en && !master && !ss_s)     st_nx = ST_SXFER;
            end
            ST_MLOW: begin
                if (m_fault || !(en && master))      st_nx = ST_IDLE;
                else if (tick)                       st_nx = ST_MHIGH;
            end
            ST_MHIGH: begin
                if (m_fault || !(en && master))      st_nx = ST_IDLE;
                else if (tick)                       st_nx = last_bit ? ST_IDLE : ST_MLOW;
            end
            ST_SXFER: begin
                if (!en || master)                   st_nx = ST_IDLE;
                else if (ss_s)                       st_nx = s_mid ? ST_SFAULT : ST_IDLE;
            end
            ST_SFAULT: begin
                if (!en || master)                   st_nx = ST_IDLE;
                else if (!ss_s)                      st_nx = ST_SXFER;
            end
            default:                                 st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= 1'b0; master <= 1'b0; lsb <= 1'b0; txe_ie <= 1'b0; mf_ie <= 1'b0;
            shreg <= '0; rx_buf <= '0; samp <= 1'b0; phase_hi <= 1'b0; bcnt <= '0;
            done <= 1'b0; txe <= 1'b1; mfault <= 1'b0; sck_d <= 1'b0;
        end else begin
            sck_d <= sck_s;
            if (wr_ctrl) begin
                en     <= wdata[C_EN];
                master <= wdata[C_MASTER];
                lsb    <= wdata[C_LSB];
                txe_ie <= wdata[C_TXEIE];
                mf_ie  <= wdata[C_MFIE];
            end
            if (m_fault) en <= 1'b0;

            if (st == ST_IDLE || st == ST_SFAULT) begin
                bcnt     <= '0;
                phase_hi <= 1'b0;
            end
            if (wr_data && can_load) begin
                shreg <= wdata;
                txe   <= 1'b0;
            end

            if (st == ST_MLOW && tick) samp <= miso_i;
            if (st == ST_MHIGH && tick && !m_fault) begin
                shreg <= shifted;
                bcnt  <= last_bit ? '0 : bcnt + BCW'(1);
            end

            if (st == ST_SXFER && !ss_s && sck_rise) begin
                samp     <= mosi_s;
                phase_hi <= 1'b1;
            end
            if (st == ST_SXFER && !ss_s && sck_fall) begin
                shreg    <= shifted;
                phase_hi <= 1'b0;
                bcnt     <= last_bit ? '0 : bcnt + BCW'(1);
            end
            if (s_fault) begin
                bcnt     <= '0;
                phase_hi <= 1'b0;
            end

            if (rd_data) done <= 1'b0;
            if (byte_end) begin
                rx_buf <= shifted;
                done   <= 1'b1;
                txe    <= 1'b1;
            end

            if (rd_stat)             mfault <= 1'b0;
            if (m_fault || s_fault)  mfault <= 1'b1;
        end
    end

    // outputs
    assign sck_o  = (st == ST_MHIGH);
    assign mosi_o = m_active ? bit_out : 1'b0;
    assign miso_o = (en && !master && !ss_s) ? bit_out : 1'b0;
    assign irq    = (txe_ie ? txe : done) | (mf_ie & mfault);

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[C_EN]     = en;
                rdata[C_MASTER] = master;
                rdata[C_LSB]    = lsb;
                rdata[C_TXEIE]  = txe_ie;
                rdata[C_MFIE]   = mf_ie;
            end
            A_STAT: begin
                rdata[S_DONE]   = done;
                rdata[S_TXE]    = txe;
                rdata[S_MFAULT] = mfault;
            end
            A_DATA:  rdata = rx_buf;
            default: rdata = '0;
        endcase
    end

    // R7: the fault that sets the flag also drops the enable
    p_fault_drops_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mfault) && master) |-> !en);

    // R7: after a master fault the serial clock is low
    p_fault_stops_sck_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_fault |=> !sck_o);

    // R5: transmit-empty stays low while a master byte is in flight
    p_txe_low_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        m_active |-> !txe);

    // R6: the receive buffer changes only when a byte completes
    p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_buf != $past(rx_buf)) |-> done);

endmodule

// File: tb/spi_mf_ctrl_test.sv
`timescale 1ns/1ps
module spi_mf_ctrl_test;
    localparam int HALF = 2;
    localparam logic [1:0] AC = 2'd0, AS = 2'd1, AD = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic irq, sck_o, mosi_o, miso_o, miso_i;
    logic sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

    int n_chk = 0, n_err = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    spi_mf_ctrl #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq),
        .sck_i(sck_i), .sck_o(sck_o), .mosi_i(mosi_i), .mosi_o(mosi_o),
        .miso_i(miso_i), .miso_o(miso_o), .ss_n_i(ss_n_i)
    );

    // bench slave used in master-mode tests
    logic [7:0] sm_tx = '0, sm_rx = '0;
    logic sm_lsb = 1'b0;
    assign miso_i = sm_lsb ? sm_tx[0] : sm_tx[7];
    always @(posedge sck_o) sm_rx = sm_lsb ? {mosi_o, sm_rx[7:1]} : {sm_rx[6:0], mosi_o};
    always @(negedge sck_o) sm_tx = sm_lsb ? (sm_tx >> 1) : (sm_tx << 1);

    // R4 monitor: high-pulse length and pulse count
    int hi_run = 0, r4_bad = 0, rises = 0;
    always @(negedge clk) begin
        if (sck_o) hi_run++;
        else begin
            if (hi_run != 0 && hi_run != HALF) r4_bad++;
            hi_run = 0;
        end
    end
    always @(posedge sck_o) rises++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    // scoreboard: driver pushes, monitor pops and compares
    task automatic sb_push(input logic [7:0] b);
        exp_q.push_back(b);
    endtask

    task automatic sb_pop(input string req);
        logic [7:0] d, e;
        rd(AD, d);
        if (exp_q.size() == 0) begin
            check(req, d, 8'hxx);
        end else begin
            e = exp_q.pop_front();
            check(req, d, e);
        end
    endtask

    task automatic wait_done(input string req);
        logic [7:0] s;
        bit ok;
        ok = 1'b0;
        for (int i = 0; i < 400 && !ok; i++) begin
            rd(AS, s);
            if (s[0]) ok = 1'b1;
        end
        check(req, ok, 1'b1);
    endtask

    task automatic m_xfer(input logic [7:0] tx, input logic [7:0] sl, input bit lsb,
                          input logic [7:0] prev, input string req);
        logic [7:0] s, d;
        wr(AC, {5'b0, lsb, 2'b11});
        sm_tx = sl; sm_rx = '0; sm_lsb = lsb; rises = 0;
        sb_push(sl);
        wr(AD, tx);
        rd(AS, s);
        check("R5 txe low in flight", s[1], 1'b0);
        rd(AD, d);
        check("R6 read returns previous byte", d, prev);
        wait_done(req);
        check(req, sm_rx, tx);
        check("R4 eight sck pulses", rises, 8);
        sb_pop(req);
        rd(AS, s);
        check("R5 done cleared txe set", s[1:0], 2'b10);
    endtask

    task automatic s_bits(input logic [7:0] mtx, input bit lsb, input int n,
                          output logic [7:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            int idx;
            idx = lsb ? i : 7 - i;
            mosi_i = mtx[idx];
            repeat (6) @(negedge clk);
            got[idx] = miso_o;
            sck_i = 1'b1;
            repeat (6) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic s_xfer(input logic [7:0] mtx, input logic [7:0] dtx, input bit lsb,
                          input string req);
        logic [7:0] got;
        wr(AC, {5'b0, lsb, 2'b01});
        wr(AD, dtx);
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        s_bits(mtx, lsb, 8, got);
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
        check(req, got, dtx);
        sb_push(mtx);
        sb_pop(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] s, d, got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(AC, d); check("R1 ctrl", d, 8'h00);
        rd(AS, s); check("R1 status", s, 8'h02);
        check("R1 irq", irq, 1'b0);
        check("R1 sck_o", sck_o, 1'b0);
        check("R1 miso_o", miso_o, 1'b0);

        // R2 / R3 master transfers, both orders
        m_xfer(8'hA5, 8'h3C, 1'b0, 8'h00, "R2 msb-first master");
        m_xfer(8'h1E, 8'hC6, 1'b1, 8'h3C, "R3 lsb-first master");
        check("R4 high pulse width", r4_bad, 0);

        // R8 slave transfers, both orders
        s_xfer(8'hB4, 8'h2D, 1'b0, "R8 slave msb-first");
        s_xfer(8'h71, 8'h0D, 1'b1, "R8 slave lsb-first");

        // R9 slave fault mid-byte, then fresh byte
        wr(AC, 8'h01);
        wr(AD, 8'h55);
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        s_bits(8'hF0, 1'b0, 3, got);
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
        rd(AS, s);
        check("R9 slave fault flag, no done", {s[2], s[0]}, 2'b10);
        rd(AS, s);
        check("R10 status read clears fault", s[2], 1'b0);
        s_xfer(8'h9C, 8'h63, 1'b0, "R9 fresh byte after fault");

        // R11 interrupt source selection (slave byte left unread)
        wr(AC, 8'h01);
        wr(AD, 8'hE1);
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        s_bits(8'h4B, 1'b0, 8, got);
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
        check("R11 irq follows done", irq, 1'b1);
        wr(AC, 8'h09);
        check("R11 irq follows txe", irq, 1'b1);
        wr(AD, 8'h00);
        check("R11 done masked while txe ie set", irq, 1'b0);
        rd(AS, s);
        check("R5 done still set", s[0], 1'b1);
        wr(AC, 8'h01);
        check("R11 done restored", irq, 1'b1);
        sb_push(8'h4B);
        sb_pop("R8 slave byte");
        check("R5 done cleared by data read", irq, 1'b0);

        // R7 / R10 master fault coinciding with a status read
        wr(AC, 8'h03);
        @(negedge clk); ss_n_i = 1'b0;
        @(negedge clk);
        @(negedge clk); addr = AS; rd_en = 1'b1;
        #1 check("R10 flag clear before set edge", rdata[2], 1'b0);
        @(negedge clk); rd_en = 1'b0;
        check("R12 fault masked from irq", irq, 1'b0);
        rd(AC, d);
        check("R7 enable cleared", d[0], 1'b0);
        ss_n_i = 1'b1;
        rd(AS, s);
        check("R10 set wins over read clear", s[2], 1'b1);
        rd(AS, s);
        check("R10 cleared by next read", s[2], 1'b0);

        // R7 abort mid-transfer, R12 gated irq
        wr(AC, 8'h13);
        wr(AD, 8'hAA);
        repeat (3) @(negedge clk);
        ss_n_i = 1'b0;
        repeat (5) @(negedge clk);
        check("R7 sck low after fault", sck_o, 1'b0);
        check("R12 fault raises irq", irq, 1'b1);
        ss_n_i = 1'b1;
        rd(AS, s);
        check("R7 aborted, fault set, no done", {s[2], s[0]}, 2'b10);
        check("R12 irq drops after clear", irq, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule